// File: doc/BRIEF.md
# Memory access decode and alignment gate

This block sits between instruction decode and the data memory port of a processor core. It looks at a 16-bit instruction and recognises three memory-access groups: ordinary accesses, volatile accesses that go around the level-1 data cache while still updating it, and atomic swaps, both unconditional and compare-and-swap. For a recognised access it registers a request. The request gives the access kind, the size (1, 2, 4 or 8 bytes), the cache-bypass flag, a naturally aligned address and the store data trimmed to the access size.

Alignment depends on the privilege mode. In user mode a misaligned 16-, 32- or 64-bit access raises a fault, and in that case no request strobe is issued. In kernel mode the offending low address bits are cleared and no fault is raised. Byte accesses are never misaligned.

The block also formats data returning from memory. A combinational path zero-extends the returned value to the given access size and compares the result with a comparison register, so that the atomic sequencer can decide whether a compare-and-swap writes memory. Cache, memory and atomic sequencing are outside this block. The register width is the parameter `XLEN`, which defaults to 64.

Top module: `ldst_align_unit`

## Requirements
- R1: The major opcode sits in insn[15:11]. Opcode 30 (normal) and opcode 31 (atomic) give req_bypass=0. Opcode 14 (volatile) gives req_bypass=1.
- R2: For opcodes 30 and 14, insn[10] set gives req_kind=1 (load) and insn[10] clear gives req_kind=0 (store). insn[9:8] is copied to req_size, where 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R3: For opcode 31, insn[10] clear gives req_kind=2 (swap) and insn[10] set gives req_kind=3 (compare-and-swap). The size is taken from insn[9:8] as in R2.
- R4: In user mode (user_mode=1) a 2-byte access with addr bit 0 set, a 4-byte access with any of bits 1:0 set, or an 8-byte access with any of bits 2:0 set raises fault=1 and keeps req_valid=0.
- R5: In kernel mode (user_mode=0) fault stays 0, and req_addr equals addr_val with its low log2(bytes) bits cleared.
- R6: A 1-byte access never faults, and its address passes through unchanged.
- R7: Any major opcode other than 30, 14 or 31 gives req_valid=0 and fault=0.
- R8: For store, swap and compare-and-swap, req_wdata holds the low bytes of store_val that match the size, and its upper bits are zero. For loads, req_wdata is zero.
- R9: ld_result is ld_raw truncated to the byte count given by ld_size and zero-extended to XLEN. This path is combinational.
- R10: cas_hit is 1 exactly when ld_result equals cmp_val.
- R11: The request outputs are registered. They appear on the clock edge that samples insn_valid=1. After reset, and after any edge with insn_valid=0, both req_valid and fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction present this cycle |
| insn | input | 16 | Instruction word |
| addr_val | input | XLEN | Address register value |
| store_val | input | XLEN | Store / swap source register value |
| user_mode | input | 1 | 1 = user mode, 0 = kernel mode |
| ld_size | input | 2 | Size code of the returning load data |
| ld_raw | input | XLEN | Raw data returned from memory |
| cmp_val | input | XLEN | Comparison register for compare-and-swap |
| req_valid | output | 1 | Memory request strobe |
| req_kind | output | 2 | 0 store, 1 load, 2 swap, 3 compare-and-swap |
| req_size | output | 2 | Size code, bytes = 2**req_size |
| req_bypass | output | 1 | Bypass-and-update level-1 data cache |
| req_addr | output | XLEN | Aligned request address |
| req_wdata | output | XLEN | Size-trimmed write data |
| fault | output | 1 | Alignment fault |
| ld_result | output | XLEN | Zero-extended load result |
| cas_hit | output | 1 | Load result equals comparison register |

## Verification
The assertions assume that insn_valid, insn, addr_val and user_mode are stable and known at each sampling edge. They also assume that an instruction lasts exactly one cycle, so every registered request can be traced to the single edge before it. The stimulus changes inputs only on falling edges and holds them for one full cycle. It draws opcodes mostly from the three memory groups, with a share of other opcodes, and uses arbitrary addresses in both modes. Directed cases add every misaligned low-bit pattern for each size, plus compare values chosen to match the formatted load data exactly and to miss it by one bit.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;

  typedef enum logic [1:0] {
    KIND_STORE = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_SWAP  = 2'd2,
    KIND_CAS   = 2'd3
  } acc_kind_e;

  localparam logic [4:0] OP_NORMAL   = 5'd30;
  localparam logic [4:0] OP_VOLATILE = 5'd14;
  localparam logic [4:0] OP_ATOMIC   = 5'd31;

  // low address bits that must be zero for a given size code
  function automatic logic [2:0] align_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    align_bits = 3'b000;
      2'd1:    align_bits = 3'b001;
      2'd2:    align_bits = 3'b011;
      default: align_bits = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_align_pkg::*;
(
  input  logic [15:0] insn,
  output logic        hit,
  output acc_kind_e   kind,
  output logic [1:0]  size,
  output logic        bypass
);
  logic [4:0] major;
  logic       sub_hi;

  assign major  = insn[15:11];
  assign sub_hi = insn[10];
  assign size   = insn[9:8];

  always_comb begin
    hit    = 1'b0;
    bypass = 1'b0;
    kind   = KIND_STORE;
    case (major)
      OP_NORMAL: begin
        hit  = 1'b1;
        kind = sub_hi ? KIND_LOAD : KIND_STORE;
      end
      OP_VOLATILE: begin
        hit    = 1'b1;
        bypass = 1'b1;
        kind   = sub_hi ? KIND_LOAD : KIND_STORE;
      end
      OP_ATOMIC: begin
        hit  = 1'b1;
        kind = sub_hi ? KIND_CAS : KIND_SWAP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ldst_align.sv
module ldst_align
  import ldst_align_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] addr_in,
  input  logic [1:0]      size,
  input  logic            user_mode,
  output logic            misaligned,
  output logic [XLEN-1:0] addr_out
);
  localparam int HI = XLEN - 3;

  logic [2:0]      low_sel;
  logic [XLEN-1:0] clr_mask;

  assign low_sel    = align_bits(size);
  assign clr_mask   = {{HI{1'b1}}, ~low_sel};
  assign misaligned = user_mode && (|(addr_in[2:0] & low_sel));
  assign addr_out   = addr_in & clr_mask;
endmodule

// File: rtl/ldst_trim.sv
module ldst_trim #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] din,
  output logic [XLEN-1:0] dout
);
  localparam int NBYTES = XLEN / 8;

  logic [3:0] keep_bytes;
  assign keep_bytes = 4'd1 << size;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign dout[b*8 +: 8] = (b < int'(keep_bytes)) ? din[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
  import ldst_align_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [15:0]     insn,
  input  logic [XLEN-1:0] addr_val,
  input  logic [XLEN-1:0] store_val,
  input  logic            user_mode,
  input  logic [1:0]      ld_size,
  input  logic [XLEN-1:0] ld_raw,
  input  logic [XLEN-1:0] cmp_val,
  output logic            req_valid,
  output logic [1:0]      req_kind,
  output logic [1:0]      req_size,
  output logic            req_bypass,
  output logic [XLEN-1:0] req_addr,
  output logic [XLEN-1:0] req_wdata,
  output logic            fault,
  output logic [XLEN-1:0] ld_result,
  output logic            cas_hit
);
  // decode
  logic        dec_hit;
  acc_kind_e   dec_kind;
  logic [1:0]  dec_size;
  logic        dec_bypass;

  ldst_decode u_dec (
    .insn   (insn),
    .hit    (dec_hit),
    .kind   (dec_kind),
    .size   (dec_size),
    .bypass (dec_bypass)
  );

  // alignment
  logic            dec_misaligned;
  logic [XLEN-1:0] dec_addr;

  ldst_align #(.XLEN(XLEN)) u_align (
    .addr_in    (addr_val),
    .size       (dec_size),
    .user_mode  (user_mode),
    .misaligned (dec_misaligned),
    .addr_out   (dec_addr)
  );

  // store data trim
  logic [XLEN-1:0] st_trim;
  ldst_trim #(.XLEN(XLEN)) u_st_trim (
    .size (dec_size),
    .din  (store_val),
    .dout (st_trim)
  );

  // load data formatting
  ldst_trim #(.XLEN(XLEN)) u_ld_trim (
    .size (ld_size),
    .din  (ld_raw),
    .dout (ld_result)
  );
  assign cas_hit = (ld_result == cmp_val);

  // named events
  logic take_req;
  logic take_fault;
  assign take_fault = insn_valid && dec_hit && dec_misaligned;
  assign take_req   = insn_valid && dec_hit && !dec_misaligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      fault      <= 1'b0;
      req_kind   <= 2'd0;
      req_size   <= 2'd0;
      req_bypass <= 1'b0;
      req_addr   <= '0;
      req_wdata  <= '0;
    end else begin
      req_valid <= take_req;
      fault     <= take_fault;
      if (insn_valid && dec_hit) begin
        req_kind   <= dec_kind;
        req_size   <= dec_size;
        req_bypass <= dec_bypass;
        req_addr   <= dec_addr;
        req_wdata  <= (dec_kind == KIND_LOAD) ? '0 : st_trim;
      end
    end
  end

  // assertions
  a_r4_fault_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !req_valid);

  a_r5_kernel_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !user_mode) |=> !fault);

  a_r5_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_addr[2:0] & align_bits(req_size)) == 3'b000));

  a_r6_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[9:8] == 2'd0) |=> !fault);

  a_r7_other_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !dec_hit) |=> (!req_valid && !fault));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> (!req_valid && !fault));

  a_r8_load_no_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1) |-> (req_wdata == '0));
endmodule

// File: tb/ldst_align_unit_bench.sv
module ldst_align_unit_bench;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            insn_valid = 1'b0;
  logic [15:0]     insn = '0;
  logic [XLEN-1:0] addr_val = '0;
  logic [XLEN-1:0] store_val = '0;
  logic            user_mode = 1'b0;
  logic [1:0]      ld_size = '0;
  logic [XLEN-1:0] ld_raw = '0;
  logic [XLEN-1:0] cmp_val = '0;
  logic            req_valid, req_bypass, fault, cas_hit;
  logic [1:0]      req_kind, req_size;
  logic [XLEN-1:0] req_addr, req_wdata, ld_result;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  ldst_align_unit #(.XLEN(XLEN)) u_ldst_align_unit (.*);

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] keep_low(input logic [63:0] v, input int nbytes);
    logic [63:0] m;
    m = (nbytes >= 8) ? {64{1'b1}} : ((64'd1 << (nbytes * 8)) - 64'd1);
    return v & m;
  endfunction

  // one instruction, checked at the following falling edge
  task automatic run_one(input logic [15:0] ins, input logic [63:0] a,
                         input logic [63:0] sv, input logic um);
    int          op, sz, nb;
    bit          mem, isload, flt;
    logic [1:0]  ekind;
    logic [63:0] eaddr, ewd;
    string       tg;
    insn = ins; addr_val = a; store_val = sv; user_mode = um; insn_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    op = int'(ins[15:11]);
    sz = int'(ins[9:8]);
    nb = 1 << sz;
    mem = (op == 30) || (op == 14) || (op == 31);
    isload = (op != 31) && ins[10];
    if (op == 31) ekind = ins[10] ? 2'd3 : 2'd2;
    else          ekind = ins[10] ? 2'd1 : 2'd0;
    flt = mem && um && ((a % 64'(nb)) != 0);
    eaddr = (a / 64'(nb)) * 64'(nb);
    ewd = isload ? 64'd0 : keep_low(sv, nb);
    if (!mem) begin
      chk("R7 req_valid", 64'(req_valid), 64'd0);
      chk("R7 fault", 64'(fault), 64'd0);
    end else if (flt) begin
      chk("R4 fault", 64'(fault), 64'd1);
      chk("R4 req_valid", 64'(req_valid), 64'd0);
    end else begin
      tg = (sz == 0) ? "R6" : (um ? "R4" : "R5");
      chk({tg, " fault"}, 64'(fault), 64'd0);
      chk({tg, " req_valid"}, 64'(req_valid), 64'd1);
      chk({tg, " req_addr"}, req_addr, eaddr);
      chk("R1 bypass", 64'(req_bypass), 64'(op == 14));
      chk((op == 31) ? "R3 kind" : "R2 kind", 64'(req_kind), 64'(ekind));
      chk("R2 size", 64'(req_size), 64'(sz));
      chk("R8 wdata", req_wdata, ewd);
    end
  endtask

  task automatic load_chk(input logic [1:0] s, input logic [63:0] raw, input logic [63:0] c);
    logic [63:0] e;
    ld_size = s; ld_raw = raw; cmp_val = c;
    #1;
    e = keep_low(raw, 1 << s);
    chk("R9 ld_result", ld_result, e);
    chk("R10 cas_hit", 64'(cas_hit), 64'(e == c));
  endtask

  function automatic logic [15:0] mk(input int op, input int sub);
    return {5'(op), 3'(sub), 8'h5a};
  endfunction

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset req_valid", 64'(req_valid), 64'd0);
    chk("R11 reset fault", 64'(fault), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: every low-bit pattern, every size, both modes
    for (int s = 0; s < 4; s++) begin
      for (int lo = 0; lo < 8; lo++) begin
        run_one(mk(30, 4 + s), 64'h1234_5678_9abc_de00 | 64'(lo), 64'hfedc_ba98_7654_3210, 1'b1);
        run_one(mk(14, s), 64'h0000_0000_0000_1000 | 64'(lo), 64'hfedc_ba98_7654_3210, 1'b0);
        run_one(mk(31, 4 + s), 64'h8000_0000_0000_0000 | 64'(lo), 64'h0123_4567_89ab_cdef, 1'b0);
      end
    end
    // R7 other opcodes, misaligned user address
    run_one(mk(0, 1), 64'h3, 64'h1, 1'b1);
    run_one(mk(29, 7), 64'h7, 64'h1, 1'b1);
    run_one(mk(15, 3), 64'h5, 64'h1, 1'b0);
    // R11 idle cycle after a request
    run_one(mk(30, 4), 64'h10, 64'h0, 1'b0);
    @(negedge clk);
    chk("R11 idle req_valid", 64'(req_valid), 64'd0);
    chk("R11 idle fault", 64'(fault), 64'd0);

    // directed load formatting / compare
    load_chk(2'd0, 64'hffff_ffff_ffff_ff80, 64'h80);
    load_chk(2'd1, 64'hffff_ffff_ffff_8001, 64'h8000);
    load_chk(2'd2, 64'hdead_beef_cafe_f00d, 64'hcafe_f00d);
    load_chk(2'd3, 64'hdead_beef_cafe_f00d, 64'hdead_beef_cafe_f00d);
    load_chk(2'd3, 64'hdead_beef_cafe_f00d, 64'hdead_beef_cafe_f00c);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int          pick, op;
      logic [63:0] a, sv, raw, c;
      logic [1:0]  s;
      pick = int'($urandom_range(0, 9));
      if (pick < 3) op = 30;
      else if (pick < 6) op = 14;
      else if (pick < 9) op = 31;
      else op = int'($urandom_range(0, 29));
      a  = {$urandom, $urandom};
      sv = {$urandom, $urandom};
      run_one(mk(op, int'($urandom_range(0, 7))), a, sv, 1'($urandom));
      s   = 2'($urandom);
      raw = {$urandom, $urandom};
      c   = ($urandom_range(0, 1) == 1) ? keep_low(raw, 1 << s) : {$urandom, $urandom};
      load_chk(s, raw, c);
      @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule